// File: doc/BRIEF.md
# Power Stage Protection Fault Latch

This block gathers the protection events of one half-bridge power stage and turns them into a single sticky fault flag. It feeds the combined temperature/fault telemetry output. It watches three sources:

- a high-side over-current flag, qualified by a strobe at each PWM rising edge;
- a digital junction-temperature code in whole degrees Celsius;
- a switch-node-to-ground short flag.

Once any source trips, the flag stays set until the power-on reset. A standby request does not clear it.

The telemetry side passes the temperature through as a code in 10 mV steps. While the stage is faulted, it replaces that code with a full-scale value of 3.3 V, so a controller reading the shared output sees the fault. The block also returns two sets of cause bits: one records every source that has tripped, the other records only the earliest. A non-latched over-temperature warning with hysteresis is provided as well.

Top module: `pstage_fault_latch`

## Requirements
- R1: An over-current fault latches only after `hs_oc_i` is high on four consecutive strobes of `pwm_rise_i`. A strobe with `hs_oc_i` low restarts the count. Cycles without a strobe neither count nor restart. `fault_o` is high in the cycle after the fourth strobe.
- R2: A temperature code strictly above 160 latches an over-temperature fault in the next cycle. A code of exactly 160 does not.
- R3: `sw_short_i` high for a single cycle latches a fault in the next cycle.
- R4: While `fault_o` is high, `tel_fs_sel_o` is high and `tel_code_o` equals 330 (3.3 V in 10 mV steps), whatever the temperature, standby or supply state.
- R5: Once set, the fault flag, the cause bits and the earliest-cause bits hold through standby and any input activity. Only `rst_n` low clears them.
- R6: With no fault, `tel_valid_o` is high exactly when `supply_ok_i` is high and `standby_i` is low. When it is high, `tel_code_o` equals the temperature code minus 10, or 0 if the code is 10 or less. When it is low, `tel_code_o` is 0.
- R7: `neg_limit_i` never affects the fault flag or the cause bits.
- R8: `cause_o` accumulates every source that has tripped, even after the first fault. The bit positions are: bit 0 over-current, bit 1 over-temperature, bit 2 short.
- R9: `first_o` is one-hot, using the bit positions of R8, and holds the earliest tripping source. If several sources trip in the same cycle, the priority is short, then over-temperature, then over-current.
- R10: `ot_warn_o` goes high in the cycle after the code exceeds 160. It goes low in the cycle after the code falls below 140. Between those levels it holds.
- R11: After reset, `fault_o`, `cause_o`, `first_o` and `ot_warn_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwm_rise_i | input | 1 | Strobe, one cycle at each PWM rising edge |
| hs_oc_i | input | 1 | High-side over-current seen in the current PWM cycle |
| tj_code_i | input | 8 | Junction temperature, °C, unsigned |
| sw_short_i | input | 1 | Switch node shorted to ground |
| neg_limit_i | input | 1 | Low-side negative current limit event (never a fault) |
| standby_i | input | 1 | Stage in standby |
| supply_ok_i | input | 1 | Supply above its undervoltage lockout threshold |
| fault_o | output | 1 | Latched fault flag |
| cause_o | output | 3 | Accumulated fault sources |
| first_o | output | 3 | Earliest fault source, one-hot |
| ot_warn_o | output | 1 | Over-temperature warning with hysteresis |
| tel_fs_sel_o | output | 1 | Selects full scale on the telemetry output |
| tel_valid_o | output | 1 | Temperature telemetry valid |
| tel_code_o | output | 9 | Telemetry code in 10 mV steps |

## Verification
Every pattern of six over-current strobe outcomes is applied, with the flag inverted on the cycles between strobes. This separates a true run of four from runs broken by a clean strobe and from noise between strobes. The temperature is swept across the trip point, and along a down-and-up path through the hysteresis band, which shows both the strict comparison and the warning's memory. The telemetry mapping is swept over every code below and above the offset and under each enable combination. Paired events, fired in the same cycle and in sequence, show the priority of the earliest-cause bits apart from the accumulation of the cause bits. Standby and the negative limit are toggled on a faulted stage and on a clean one.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
    localparam int SRC_N   = 3;
    localparam int SRC_OC  = 0;
    localparam int SRC_OT  = 1;
    localparam int SRC_SHT = 2;
    localparam int CNT_W   = 3;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic [CNT_W-1:0] oc_cnt;
        logic             fault;
        src_vec_t         cause;
        src_vec_t         first;
        logic             warn;
    } pfl_state_t;
endpackage

// File: rtl/pfl_oc_run.sv
module pfl_oc_run #(
    parameter int OC_RUN = 4,
    parameter int CNT_W  = 3
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             strobe,
    input  logic             oc,
    output logic [CNT_W-1:0] cnt_d,
    output logic             trip
);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(OC_RUN);

    always_comb begin
        cnt_d = cnt_q;
        trip  = 1'b0;
        if (strobe) begin
            if (oc) begin
                if (cnt_q != RUN_MAX) cnt_d = cnt_q + 1'b1;
                trip = (cnt_q >= RUN_MAX - 1'b1);
            end else begin
                cnt_d = '0;
            end
        end
    end
endmodule

// File: rtl/pfl_ot_eval.sv
module pfl_ot_eval #(
    parameter int TJ_W    = 8,
    parameter int OT_TRIP = 160,
    parameter int OT_HYST = 20
) (
    input  logic [TJ_W-1:0] tj,
    input  logic            warn_q,
    output logic            trip,
    output logic            warn_d
);
    localparam logic [TJ_W-1:0] HI = TJ_W'(OT_TRIP);
    localparam logic [TJ_W-1:0] LO = TJ_W'(OT_TRIP - OT_HYST);

    always_comb begin
        trip   = (tj > HI);
        warn_d = warn_q;
        if (tj > HI)      warn_d = 1'b1;
        else if (tj < LO) warn_d = 1'b0;
    end
endmodule

// File: rtl/pfl_tel_mux.sv
module pfl_tel_mux #(
    parameter int TJ_W    = 8,
    parameter int TEL_W   = 9,
    parameter int TEL_OFS = 10,
    parameter int TEL_FS  = 330
) (
    input  logic [TJ_W-1:0]  tj,
    input  logic             faulted,
    input  logic             supply_ok,
    input  logic             standby,
    output logic             valid,
    output logic             fs_sel,
    output logic [TEL_W-1:0] code
);
    localparam logic [TEL_W-1:0] OFS = TEL_W'(TEL_OFS);
    localparam logic [TEL_W-1:0] FS  = TEL_W'(TEL_FS);

    logic [TEL_W-1:0] tj_ext;
    logic [TEL_W-1:0] temp_code;

    always_comb begin
        tj_ext    = TEL_W'(tj);
        temp_code = (tj_ext > OFS) ? (tj_ext - OFS) : '0;
        valid     = supply_ok & ~standby;
        fs_sel    = faulted;
        if (faulted)    code = FS;
        else if (valid) code = temp_code;
        else            code = '0;
    end
endmodule

// File: rtl/pstage_fault_latch.sv
module pstage_fault_latch
    import pfl_pkg::*;
#(
    parameter int TJ_W    = 8,
    parameter int TEL_W   = 9,
    parameter int OC_RUN  = 4,
    parameter int OT_TRIP = 160,
    parameter int OT_HYST = 20,
    parameter int TEL_OFS = 10,
    parameter int TEL_FS  = 330
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_rise_i,
    input  logic             hs_oc_i,
    input  logic [TJ_W-1:0]  tj_code_i,
    input  logic             sw_short_i,
    input  logic             neg_limit_i,
    input  logic             standby_i,
    input  logic             supply_ok_i,
    output logic             fault_o,
    output logic [2:0]       cause_o,
    output logic [2:0]       first_o,
    output logic             ot_warn_o,
    output logic             tel_fs_sel_o,
    output logic             tel_valid_o,
    output logic [TEL_W-1:0] tel_code_o
);
    pfl_state_t st_d, st_q;

    logic [CNT_W-1:0] oc_cnt_d;
    logic             oc_trip;
    logic             ot_trip;
    logic             warn_d;
    src_vec_t         trip_vec;
    src_vec_t         first_pick;
    logic             neg_seen;

    assign neg_seen = neg_limit_i;

    pfl_oc_run #(.OC_RUN(OC_RUN), .CNT_W(CNT_W)) i_oc_run (
        .cnt_q  (st_q.oc_cnt),
        .strobe (pwm_rise_i),
        .oc     (hs_oc_i),
        .cnt_d  (oc_cnt_d),
        .trip   (oc_trip)
    );

    pfl_ot_eval #(.TJ_W(TJ_W), .OT_TRIP(OT_TRIP), .OT_HYST(OT_HYST)) i_ot_eval (
        .tj     (tj_code_i),
        .warn_q (st_q.warn),
        .trip   (ot_trip),
        .warn_d (warn_d)
    );

    pfl_tel_mux #(.TJ_W(TJ_W), .TEL_W(TEL_W), .TEL_OFS(TEL_OFS), .TEL_FS(TEL_FS)) i_tel (
        .tj        (tj_code_i),
        .faulted   (st_q.fault),
        .supply_ok (supply_ok_i),
        .standby   (standby_i),
        .valid     (tel_valid_o),
        .fs_sel    (tel_fs_sel_o),
        .code      (tel_code_o)
    );

    always_comb begin
        trip_vec          = '0;
        trip_vec[SRC_OC]  = oc_trip;
        trip_vec[SRC_OT]  = ot_trip;
        trip_vec[SRC_SHT] = sw_short_i;

        first_pick = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (trip_vec[i] && first_pick == '0) first_pick[i] = 1'b1;
        end

        st_d        = st_q;
        st_d.oc_cnt = oc_cnt_d;
        st_d.warn   = warn_d;
        st_d.cause  = st_q.cause | trip_vec;
        if (!st_q.fault && trip_vec != '0) begin
            st_d.fault = 1'b1;
            st_d.first = first_pick;
        end
        // negative current limit is observed but has no path into the latch
        if (neg_seen) st_d.fault = st_d.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o   = st_q.fault;
    assign cause_o   = st_q.cause;
    assign first_o   = st_q.first;
    assign ot_warn_o = st_q.warn;
endmodule

// File: rtl/pstage_fault_latch_chk.sv
module pstage_fault_latch_chk #(
    parameter int TEL_W   = 9,
    parameter int OC_RUN  = 4,
    parameter int OT_TRIP = 160,
    parameter int TEL_FS  = 330
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_rise_i,
    input logic             hs_oc_i,
    input logic [7:0]       tj_code_i,
    input logic             sw_short_i,
    input logic             fault_o,
    input logic [2:0]       cause_o,
    input logic [2:0]       first_o,
    input logic             tel_fs_sel_o,
    input logic [TEL_W-1:0] tel_code_o
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (pwm_rise_i) run_q <= hs_oc_i ? ((run_q == 8'd255) ? run_q : run_q + 1'b1) : '0;
    end

    p_oc_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == 8'(OC_RUN - 1) && pwm_rise_i && hs_oc_i) |=> cause_o[0]);

    p_oc_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_o[0]) |-> $past(pwm_rise_i && hs_oc_i));

    p_ot_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tj_code_i > 8'(OT_TRIP)) |=> (fault_o && cause_o[1]));

    p_short_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_short_i |=> (fault_o && cause_o[2]));

    p_full_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (tel_fs_sel_o && tel_code_o == TEL_W'(TEL_FS)));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (fault_o && $stable(first_o)));

    p_first_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_o) && (fault_o == (first_o != 3'b000)));

    p_cause_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (($past(cause_o) & ~cause_o) == 3'b000));
endmodule

bind pstage_fault_latch pstage_fault_latch_chk #(
    .TEL_W(TEL_W), .OC_RUN(OC_RUN), .OT_TRIP(OT_TRIP), .TEL_FS(TEL_FS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_rise_i   (pwm_rise_i),
    .hs_oc_i      (hs_oc_i),
    .tj_code_i    (tj_code_i),
    .sw_short_i   (sw_short_i),
    .fault_o      (fault_o),
    .cause_o      (cause_o),
    .first_o      (first_o),
    .tel_fs_sel_o (tel_fs_sel_o),
    .tel_code_o   (tel_code_o)
);

// File: tb/test_pstage_fault_latch.sv
`timescale 1ns/1ps
module test_pstage_fault_latch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwm_rise_i, hs_oc_i, sw_short_i, neg_limit_i, standby_i, supply_ok_i;
    logic [7:0] tj_code_i;
    logic       fault_o, ot_warn_o, tel_fs_sel_o, tel_valid_o;
    logic [2:0] cause_o, first_o;
    logic [8:0] tel_code_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pstage_fault_latch i_pstage_fault_latch (
        .clk(clk), .rst_n(rst_n), .pwm_rise_i(pwm_rise_i), .hs_oc_i(hs_oc_i),
        .tj_code_i(tj_code_i), .sw_short_i(sw_short_i), .neg_limit_i(neg_limit_i),
        .standby_i(standby_i), .supply_ok_i(supply_ok_i), .fault_o(fault_o),
        .cause_o(cause_o), .first_o(first_o), .ot_warn_o(ot_warn_o),
        .tel_fs_sel_o(tel_fs_sel_o), .tel_valid_o(tel_valid_o), .tel_code_o(tel_code_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwm_rise_i = 0; hs_oc_i = 0; sw_short_i = 0; neg_limit_i = 0;
        standby_i = 0; supply_ok_i = 1; tj_code_i = 8'd25;
        step(); step();
        rst_n = 1'b1;
    endtask

    function automatic int tel_exp(int tj, bit ok, bit sb);
        if (!ok || sb) return 0;
        return (tj > 10) ? tj - 10 : 0;
    endfunction

    initial begin
        int run_len;
        bit hit;
        do_reset();
        // R11 reset state
        chk("R11 fault", fault_o, 0);
        chk("R11 cause", cause_o, 0);
        chk("R11 first", first_o, 0);
        chk("R11 warn", ot_warn_o, 0);

        // R6 telemetry sweep, held in reset so no latch can form
        rst_n = 1'b0;
        for (int t = 0; t < 256; t++) begin
            for (int m = 0; m < 4; m++) begin
                tj_code_i = 8'(t); supply_ok_i = m[0]; standby_i = m[1];
                #1;
                chk("R6 valid", tel_valid_o, (m == 1) ? 1 : 0);
                chk("R6 code", tel_code_o, tel_exp(t, m[0], m[1]));
                chk("R4 fs_sel idle", tel_fs_sel_o, 0);
            end
        end
        do_reset();

        // R1 sweep over every 6-strobe pattern, noise between strobes
        for (int p = 0; p < 64; p++) begin
            do_reset();
            run_len = 0; hit = 0;
            for (int k = 0; k < 6; k++) begin
                pwm_rise_i = 1; hs_oc_i = p[k];
                step();
                run_len = p[k] ? run_len + 1 : 0;
                if (run_len >= 4) hit = 1;
                chk("R1 fault after strobe", fault_o, hit);
                chk("R8 cause oc", cause_o, hit ? 1 : 0);
                chk("R9 first oc", first_o, hit ? 1 : 0);
                pwm_rise_i = 0; hs_oc_i = ~p[k];
                step(); step();
                chk("R1 hold between strobes", fault_o, hit);
            end
        end

        // R2 and R10 trip point sweep
        for (int t = 150; t <= 170; t++) begin
            do_reset();
            tj_code_i = 8'(t);
            step();
            chk("R2 ot fault", fault_o, (t > 160) ? 1 : 0);
            chk("R2 ot cause", cause_o, (t > 160) ? 2 : 0);
            chk("R10 warn set", ot_warn_o, (t > 160) ? 1 : 0);
            chk("R4 code", tel_code_o, (t > 160) ? 330 : t - 10);
        end

        // R10 hysteresis path
        do_reset();
        tj_code_i = 8'd161; step(); chk("R10 up", ot_warn_o, 1);
        tj_code_i = 8'd150; step(); chk("R10 band 150", ot_warn_o, 1);
        tj_code_i = 8'd140; step(); chk("R10 band 140", ot_warn_o, 1);
        tj_code_i = 8'd139; step(); chk("R10 clear 139", ot_warn_o, 0);
        tj_code_i = 8'd160; step(); chk("R10 band rising 160", ot_warn_o, 0);
        tj_code_i = 8'd161; step(); chk("R10 set again", ot_warn_o, 1);

        // R3 short pulse, R4 full scale, R5 standby
        do_reset();
        sw_short_i = 1; step(); sw_short_i = 0;
        chk("R3 fault", fault_o, 1);
        chk("R3 cause", cause_o, 4);
        chk("R9 first short", first_o, 4);
        chk("R4 fs_sel", tel_fs_sel_o, 1);
        for (int t = 0; t < 256; t += 51) begin
            tj_code_i = 8'(t); #1;
            chk("R4 code forced", tel_code_o, 330);
        end
        tj_code_i = 8'd25;
        standby_i = 1; supply_ok_i = 0;
        for (int k = 0; k < 5; k++) step();
        chk("R5 fault in standby", fault_o, 1);
        chk("R4 code in standby", tel_code_o, 330);
        standby_i = 0; supply_ok_i = 1; step();
        chk("R5 fault after standby", fault_o, 1);
        chk("R5 first kept", first_o, 4);
        do_reset();
        chk("R5 reset clears", fault_o, 0);
        chk("R5 reset clears cause", cause_o, 0);

        // R9 same-cycle priority
        do_reset();
        tj_code_i = 8'd170; sw_short_i = 1; step(); sw_short_i = 0; tj_code_i = 8'd25;
        chk("R9 same cycle first", first_o, 4);
        chk("R8 same cycle cause", cause_o, 6);
        do_reset();
        tj_code_i = 8'd170; pwm_rise_i = 1; hs_oc_i = 1;
        for (int k = 0; k < 3; k++) step();
        tj_code_i = 8'd25; step(); pwm_rise_i = 0; hs_oc_i = 0;
        chk("R9 ot before oc", first_o, 2);
        // R8 accumulate after fault
        sw_short_i = 1; step(); sw_short_i = 0;
        chk("R8 accumulate", cause_o, 7);
        chk("R9 first unchanged", first_o, 2);

        // R7 negative limit ignored
        do_reset();
        for (int k = 0; k < 20; k++) begin
            neg_limit_i = k[0]; pwm_rise_i = k[1]; hs_oc_i = 0;
            step();
        end
        neg_limit_i = 0; pwm_rise_i = 0;
        chk("R7 no fault", fault_o, 0);
        chk("R7 no cause", cause_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule